// File: doc/BRIEF.md
# Fractional Audio DSP Arithmetic Unit

This unit is the arithmetic stage of a small audio signal processor. It works on Q31 fractions and on plain 32-bit integers. On each qualified cycle it takes a 4-bit opcode and three signed 32-bit operands (A, X, Y) and registers a 32-bit result. The same clock edge also registers a 9-bit condition word that describes that result. The opcode space covers several groups: multiply-accumulate in fractional and integer forms, each with a clamping and a wrapping variant; a three-input add; a masked bit toggle; three compare-and-pick operations; and linear interpolation. One opcode forwards A to the result and adds the fractional product of X and Y into a private accumulator.

The result, condition word and accumulator are all registers. An operation presented with `in_valid` high at a rising edge appears on the outputs after that edge. While `in_valid` is low, every output register keeps its value. Operand fetch, sequencing and branching belong to the surrounding processor. The unit has no state machine: its only state is the accumulator and the three output registers.

Top module: `fdsp_alu`

## Requirements
- R1: Opcodes 0 and 2 give A + floor(X*Y / 2^31), computed on the full signed product. Opcodes 1 and 3 give A + floor(-(X*Y) / 2^31). Opcodes 0 and 1 clamp the sum. Opcodes 2 and 3 keep the low 32 bits of the sum.
- R2: Opcode 4 gives A + X*Y (integer product) and clamps it. Opcode 5 forms the same sum, keeps its low 31 bits and sign-extends bit 30 into bit 31.
- R3: Opcode 6 gives A + X + Y, clamped.
- R4: Opcode 7 places A on the result. In the same cycle it adds floor(X*Y / 2^31) into the accumulator, modulo 2^32. The accumulator is visible on `acc_out`.
- R5: Opcode 8 gives (A AND X) XOR Y.
- R6: Opcode 9 gives X if A >= Y, otherwise NOT X. Opcode 10 gives X if A >= Y, otherwise Y. Opcode 11 gives X if A < Y, otherwise Y. All comparisons are signed.
- R7: Opcode 14 gives A + floor(X*(Y-A) / 2^31), clamped. This is interpolation from A toward Y by fraction X.
- R8: A clamped operation whose exact value exceeds the signed 32-bit range returns 0x7FFFFFFF when the value is too high and 0x80000000 when it is too low. It also sets condition bit 4. Every other case clears bit 4.
- R9: The condition word is updated by each valid operation. The bits are:
  - bit 0: R[31] XOR R[30]
  - bit 1: signed A < Y
  - bit 2: R[31]
  - bit 3: R == 0
  - bit 8: R != 0
  - bits 5 to 7: always 0
- R10: Opcodes 12, 13 and 15 return A, leave the accumulator unchanged and still update the condition word.
- R11: With `in_valid` low, `r_out`, `cc_out` and `acc_out` hold their values whatever the other inputs are. `res_valid` is the registered `in_valid`.
- R12: While `rst` is high at a clock edge, `r_out`, `cc_out`, `acc_out` and `res_valid` are cleared. Reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the operation on this edge |
| opcode | input | 4 | Operation select |
| opd_a | input | 32 | Signed operand A |
| opd_x | input | 32 | Signed operand X |
| opd_y | input | 32 | Signed operand Y |
| r_out | output | 32 | Registered result |
| cc_out | output | 9 | Registered condition word |
| acc_out | output | 32 | Accumulator |
| res_valid | output | 1 | High when r_out and cc_out were written on the last edge |

## Verification
Opcode 7 is the only operation that writes two architectural values on one edge: it forwards A to the result and adds to the accumulator. The bench issues it with an A that differs from the product and reads both values after that single edge. It then streams several accumulate operations back to back, with `in_valid` held high, and one other opcode in between. The check is that the accumulator advances once per accumulate operation, never on the others, and that the result always equals that cycle's A.

// File: rtl/fdsp_pkg.sv
package fdsp_pkg;

    typedef enum logic [3:0] {
        OP_FMAC_SAT      = 4'h0,
        OP_FMAC_NEG_SAT  = 4'h1,
        OP_FMAC_WRAP     = 4'h2,
        OP_FMAC_NEG_WRAP = 4'h3,
        OP_IMAC_SAT      = 4'h4,
        OP_IMAC_WRAP31   = 4'h5,
        OP_ADD3_SAT      = 4'h6,
        OP_MOVE_ACC      = 4'h7,
        OP_AND_XOR       = 4'h8,
        OP_SEL_INV       = 4'h9,
        OP_SEL_GE        = 4'hA,
        OP_SEL_LT        = 4'hB,
        OP_RSV_C         = 4'hC,
        OP_RSV_D         = 4'hD,
        OP_INTERP        = 4'hE,
        OP_RSV_F         = 4'hF
    } fdsp_op_e;

    // How the wide sum is reduced to the result width
    typedef enum logic [1:0] {
        FIN_CLAMP,
        FIN_WRAP,
        FIN_WRAP31,
        FIN_DIRECT
    } fdsp_fin_e;

    localparam int CC_W    = 9;
    localparam int CC_NORM = 0;
    localparam int CC_BORR = 1;
    localparam int CC_NEG  = 2;
    localparam int CC_ZERO = 3;
    localparam int CC_SAT  = 4;
    localparam int CC_NZ   = 8;

endpackage

// File: rtl/fdsp_sat.sv
module fdsp_sat #(
    parameter int IN_W  = 66,
    parameter int OUT_W = 32
) (
    input  logic signed [IN_W-1:0]  in_val,
    output logic        [OUT_W-1:0] out_val,
    output logic                    clipped
);
    localparam int EXT = IN_W - OUT_W + 1;
    localparam logic signed [IN_W-1:0] MAXV = {{EXT{1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] MINV = {{EXT{1'b1}}, {(OUT_W-1){1'b0}}};

    logic too_hi;
    logic too_lo;

    assign too_hi  = in_val > MAXV;
    assign too_lo  = in_val < MINV;
    assign clipped = too_hi | too_lo;

    always_comb begin
        if (too_hi) begin
            out_val = {1'b0, {(OUT_W-1){1'b1}}};
        end else if (too_lo) begin
            out_val = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            out_val = in_val[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/fdsp_arith.sv
module fdsp_arith
    import fdsp_pkg::*;
#(
    parameter int DW = 32
) (
    input  fdsp_op_e              op,
    input  logic signed [DW-1:0]  a,
    input  logic signed [DW-1:0]  x,
    input  logic signed [DW-1:0]  y,
    output logic        [DW-1:0]  res,
    output logic                  clipped,
    output logic        [DW-1:0]  acc_step
);
    localparam int WIDE = 2 * DW + 2;
    localparam int SH   = DW - 1;

    logic signed [WIDE-1:0] ae, xe, ye;
    logic signed [WIDE-1:0] prod_xy, frac_p, frac_n;
    logic signed [WIDE-1:0] diff_ya, prod_xd, frac_i;
    logic signed [WIDE-1:0] wide_sum;
    logic        [DW-1:0]   direct_val;
    logic        [DW-1:0]   sat_val;
    logic                   sat_hit;
    logic                   a_ge_y;
    fdsp_fin_e              fin;

    assign ae = {{(WIDE-DW){a[DW-1]}}, a};
    assign xe = {{(WIDE-DW){x[DW-1]}}, x};
    assign ye = {{(WIDE-DW){y[DW-1]}}, y};

    assign prod_xy = xe * ye;
    assign frac_p  = prod_xy >>> SH;
    assign frac_n  = (-prod_xy) >>> SH;
    assign diff_ya = ye - ae;
    assign prod_xd = xe * diff_ya;
    assign frac_i  = prod_xd >>> SH;
    assign a_ge_y  = a >= y;

    always_comb begin
        wide_sum   = ae;
        direct_val = a;
        fin        = FIN_DIRECT;
        unique case (op)
            OP_FMAC_SAT:      begin wide_sum = ae + frac_p;       fin = FIN_CLAMP;  end
            OP_FMAC_NEG_SAT:  begin wide_sum = ae + frac_n;       fin = FIN_CLAMP;  end
            OP_FMAC_WRAP:     begin wide_sum = ae + frac_p;       fin = FIN_WRAP;   end
            OP_FMAC_NEG_WRAP: begin wide_sum = ae + frac_n;       fin = FIN_WRAP;   end
            OP_IMAC_SAT:      begin wide_sum = ae + prod_xy;      fin = FIN_CLAMP;  end
            OP_IMAC_WRAP31:   begin wide_sum = ae + prod_xy;      fin = FIN_WRAP31; end
            OP_ADD3_SAT:      begin wide_sum = ae + xe + ye;      fin = FIN_CLAMP;  end
            OP_INTERP:        begin wide_sum = ae + frac_i;       fin = FIN_CLAMP;  end
            OP_AND_XOR:       direct_val = (a & x) ^ y;
            OP_SEL_INV:       direct_val = a_ge_y ? x : ~x;
            OP_SEL_GE:        direct_val = a_ge_y ? x : y;
            OP_SEL_LT:        direct_val = a_ge_y ? y : x;
            OP_MOVE_ACC,
            OP_RSV_C,
            OP_RSV_D,
            OP_RSV_F:         direct_val = a;
            default:          direct_val = a;
        endcase
    end

    fdsp_sat #(.IN_W(WIDE), .OUT_W(DW)) u_sat (
        .in_val  (wide_sum),
        .out_val (sat_val),
        .clipped (sat_hit)
    );

    always_comb begin
        clipped = 1'b0;
        unique case (fin)
            FIN_CLAMP:  begin res = sat_val; clipped = sat_hit; end
            FIN_WRAP:   res = wide_sum[DW-1:0];
            FIN_WRAP31: res = {wide_sum[DW-2], wide_sum[DW-2:0]};
            FIN_DIRECT: res = direct_val;
            default:    res = direct_val;
        endcase
    end

    assign acc_step = frac_p[DW-1:0];

endmodule

// File: rtl/fdsp_ccgen.sv
module fdsp_ccgen
    import fdsp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic        [DW-1:0]  r,
    input  logic signed [DW-1:0]  a,
    input  logic signed [DW-1:0]  y,
    input  logic                  clipped,
    output logic        [CC_W-1:0] cc
);
    logic r_zero;

    assign r_zero = (r == '0);

    always_comb begin
        cc          = '0;
        cc[CC_NORM] = r[DW-1] ^ r[DW-2];
        cc[CC_BORR] = a < y;
        cc[CC_NEG]  = r[DW-1];
        cc[CC_ZERO] = r_zero;
        cc[CC_SAT]  = clipped;
        cc[CC_NZ]   = ~r_zero;
    end

endmodule

// File: rtl/fdsp_alu.sv
module fdsp_alu
    import fdsp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [3:0]           opcode,
    input  logic signed [DW-1:0] opd_a,
    input  logic signed [DW-1:0] opd_x,
    input  logic signed [DW-1:0] opd_y,
    output logic [DW-1:0]        r_out,
    output logic [CC_W-1:0]      cc_out,
    output logic [DW-1:0]        acc_out,
    output logic                 res_valid
);
    localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

    fdsp_op_e         op;
    logic [DW-1:0]    res_n;
    logic             clip_n;
    logic [DW-1:0]    step_n;
    logic [CC_W-1:0]  cc_n;
    logic             acc_we;

    assign op     = fdsp_op_e'(opcode);
    assign acc_we = in_valid && (op == OP_MOVE_ACC);

    fdsp_arith #(.DW(DW)) u_arith (
        .op       (op),
        .a        (opd_a),
        .x        (opd_x),
        .y        (opd_y),
        .res      (res_n),
        .clipped  (clip_n),
        .acc_step (step_n)
    );

    fdsp_ccgen #(.DW(DW)) u_cc (
        .r       (res_n),
        .a       (opd_a),
        .y       (opd_y),
        .clipped (clip_n),
        .cc      (cc_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            r_out     <= '0;
            cc_out    <= '0;
            acc_out   <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                r_out  <= res_n;
                cc_out <= cc_n;
            end
            if (acc_we) begin
                acc_out <= acc_out + step_n;
            end
        end
    end

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (r_out == '0) && (cc_out == '0) && (acc_out == '0) && !res_valid);

    // R9
    zero_nz_excl_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (cc_out[CC_ZERO] != cc_out[CC_NZ]));

    // R9
    zero_matches_r_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (cc_out[CC_ZERO] == (r_out == '0)));

    // R8
    clamp_value_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && cc_out[CC_SAT]) |-> ((r_out == POS_MAX) || (r_out == NEG_MIN)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(r_out) && $stable(cc_out) && !res_valid));

    // R10
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || (opcode != 4'h7)) |=> $stable(acc_out));

    // R4
    move_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (opcode == 4'h7)) |=> (r_out == $past(opd_a)));

endmodule

// File: tb/fdsp_alu_test.sv
module fdsp_alu_test;
    localparam int CLK_T = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [3:0]         opcode = 4'h0;
    logic signed [31:0] opd_a = '0;
    logic signed [31:0] opd_x = '0;
    logic signed [31:0] opd_y = '0;
    logic [31:0]        r_out;
    logic [8:0]         cc_out;
    logic [31:0]        acc_out;
    logic               res_valid;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] acc_mdl = '0;
    bit done = 1'b0;

    fdsp_alu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .opd_a(opd_a), .opd_x(opd_x), .opd_y(opd_y),
        .r_out(r_out), .cc_out(cc_out), .acc_out(acc_out), .res_valid(res_valid)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] clamp32(input longint v, output bit s);
        s = 1'b0;
        if (v > 64'sd2147483647) begin s = 1'b1; return 32'h7FFFFFFF; end
        if (v < -64'sd2147483648) begin s = 1'b1; return 32'h80000000; end
        return v[31:0];
    endfunction

    // Independent reference model of the requirements
    task automatic model(input logic [3:0] op, input logic signed [31:0] a,
                         input logic signed [31:0] x, input logic signed [31:0] y,
                         output logic [31:0] r, output logic [8:0] cc, output logic [31:0] step);
        longint av, xv, yv, s, f;
        bit sat;
        av = longint'(a); xv = longint'(x); yv = longint'(y);
        sat = 1'b0;
        f = (xv * yv) >>> 31;
        step = f[31:0];
        case (op)
            4'h0: r = clamp32(av + f, sat);
            4'h1: r = clamp32(av + ((-(xv * yv)) >>> 31), sat);
            4'h2: begin s = av + f; r = s[31:0]; end
            4'h3: begin s = av + ((-(xv * yv)) >>> 31); r = s[31:0]; end
            4'h4: r = clamp32(av + xv * yv, sat);
            4'h5: begin s = av + xv * yv; r = {s[30], s[30:0]}; end
            4'h6: r = clamp32(av + xv + yv, sat);
            4'h8: r = (a & x) ^ y;
            4'h9: r = (a >= y) ? x : ~x;
            4'hA: r = (a >= y) ? x : y;
            4'hB: r = (a < y) ? x : y;
            4'hE: r = clamp32(av + ((xv * (yv - av)) >>> 31), sat);
            default: r = a;
        endcase
        cc = '0;
        cc[0] = r[31] ^ r[30];
        cc[1] = a < y;
        cc[2] = r[31];
        cc[3] = (r == 0);
        cc[4] = sat;
        cc[8] = (r != 0);
    endtask

    // One isolated operation, checked after its edge
    task automatic exec(input string req, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] x, input logic [31:0] y);
        logic [31:0] er, st;
        logic [8:0]  ec;
        model(op, a, x, y, er, ec, st);
        if (op == 4'h7) acc_mdl = acc_mdl + st;
        @(negedge clk);
        in_valid = 1'b1; opcode = op; opd_a = a; opd_x = x; opd_y = y;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " result"}, r_out, er);
        chk({req, " R9 flags"}, {23'd0, cc_out}, {23'd0, ec});
        chk({req, " accumulator"}, acc_out, acc_mdl);
        chk({req, " R11 res_valid"}, {31'd0, res_valid}, 32'd1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        acc_mdl = '0;
        chk("R12 r_out", r_out, 32'd0);
        chk("R12 cc_out", {23'd0, cc_out}, 32'd0);
        chk("R12 acc_out", acc_out, 32'd0);
        chk("R12 res_valid", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_frac_mac;
        exec("R1 half*half", 4'h0, 32'h0, 32'h40000000, 32'h40000000);
        exec("R1 R8 clamp hi", 4'h0, 32'h7FFFFFFF, 32'h40000000, 32'h40000000);
        exec("R1 R8 min*min", 4'h0, 32'h0, 32'h80000000, 32'h80000000);
        exec("R1 wrap", 4'h2, 32'h7FFFFFFF, 32'h40000000, 32'h40000000);
        exec("R1 neg clamp lo", 4'h1, 32'h80000000, 32'h40000000, 32'h40000000);
        exec("R1 neg wrap", 4'h3, 32'h80000000, 32'h40000000, 32'h40000000);
        exec("R1 neg small", 4'h1, 32'h00001000, 32'hC0000000, 32'h20000000);
    endtask

    task automatic t_int_mac;
        exec("R2 int mixed sign", 4'h4, 32'd10, 32'd3, 32'hFFFFFFFC);
        exec("R2 R8 int clamp", 4'h4, 32'd0, 32'h00010000, 32'h00010000);
        exec("R2 wrap31 sign", 4'h5, 32'd0, 32'h00008000, 32'h00008000);
        exec("R2 wrap31 small", 4'h5, 32'd5, 32'd2, 32'd3);
    endtask

    task automatic t_add3;
        exec("R3 small", 4'h6, 32'd1, 32'd2, 32'd3);
        exec("R3 R8 clamp hi", 4'h6, 32'h7FFFFFFF, 32'd1, 32'd1);
        exec("R3 R8 clamp lo", 4'h6, 32'h80000000, 32'hFFFFFFFF, 32'd0);
        exec("R3 to zero", 4'h6, 32'd5, 32'hFFFFFFFE, 32'hFFFFFFFD);
    endtask

    task automatic t_logic_sel;
        exec("R5 and-xor", 4'h8, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0F0F0000);
        exec("R6 inv ge", 4'h9, 32'd7, 32'h12345678, 32'd7);
        exec("R6 inv lt", 4'h9, 32'hFFFFFFF0, 32'h12345678, 32'd1);
        exec("R6 ge equal", 4'hA, 32'd9, 32'hAAAA0000, 32'd9);
        exec("R6 ge below", 4'hA, 32'h80000000, 32'hAAAA0000, 32'd9);
        exec("R6 lt below", 4'hB, 32'h80000000, 32'h0000BEEF, 32'h7FFFFFFF);
        exec("R6 lt equal", 4'hB, 32'd4, 32'h0000BEEF, 32'd4);
    endtask

    task automatic t_interp;
        exec("R7 midpoint", 4'hE, 32'd0, 32'h40000000, 32'h40000000);
        exec("R7 full span", 4'hE, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF);
        exec("R7 negative frac", 4'hE, 32'h10000000, 32'h80000000, 32'hF0000000);
        exec("R7 downward", 4'hE, 32'h40000000, 32'h20000000, 32'hC0000000);
    endtask

    task automatic t_move_acc;
        exec("R4 first", 4'h7, 32'h00001234, 32'h40000000, 32'h40000000);
        exec("R4 second", 4'h7, 32'hFFFF0000, 32'h40000000, 32'h40000000);
        exec("R4 negative step", 4'h7, 32'd0, 32'h80000000, 32'h40000000);
    endtask

    // Back-to-back stream, in_valid held high
    task automatic t_stream;
        logic [31:0] er, st;
        logic [8:0]  ec;
        logic [3:0]  ops [4] = '{4'h7, 4'h6, 4'h7, 4'h7};
        logic [31:0] as  [4] = '{32'h11111111, 32'd3, 32'h22222222, 32'h80000000};
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            model(ops[i], as[i], 32'h30000000, 32'h50000000, er, ec, st);
            if (ops[i] == 4'h7) acc_mdl = acc_mdl + st;
            in_valid = 1'b1; opcode = ops[i]; opd_a = as[i];
            opd_x = 32'h30000000; opd_y = 32'h50000000;
            @(negedge clk);
            chk("R4 stream result", r_out, er);
            chk("R4 stream accumulator", acc_out, acc_mdl);
        end
        in_valid = 1'b0;
    endtask

    task automatic t_reserved;
        exec("R10 op C", 4'hC, 32'h89ABCDEF, 32'h40000000, 32'h40000000);
        exec("R10 op D", 4'hD, 32'd0, 32'h7FFFFFFF, 32'h7FFFFFFF);
        exec("R10 op F", 4'hF, 32'h40000000, 32'h40000000, 32'h7FFFFFFF);
    endtask

    task automatic t_idle;
        logic [31:0] r0, a0;
        logic [8:0]  c0;
        r0 = r_out; c0 = cc_out; a0 = acc_out;
        @(negedge clk);
        in_valid = 1'b0; opcode = 4'h7; opd_a = 32'h5555AAAA;
        opd_x = 32'h7FFFFFFF; opd_y = 32'h7FFFFFFF;
        @(negedge clk);
        opcode = 4'h0;
        @(negedge clk);
        chk("R11 idle r_out", r_out, r0);
        chk("R11 idle cc_out", {23'd0, cc_out}, {23'd0, c0});
        chk("R11 idle acc_out", acc_out, a0);
        chk("R11 idle res_valid", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_T * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_frac_mac();
        t_int_mac();
        t_add3();
        t_logic_sel();
        t_interp();
        t_move_acc();
        t_stream();
        t_reserved();
        t_idle();
        t_reset();
        exec("R12 after reset accumulate", 4'h7, 32'd1, 32'h40000000, 32'h20000000);
        finish_run();
    end

endmodule